// File: doc/BRIEF.md
# Split-Transaction Tagged Bus Master

This block drives a system bus whose address and data tenures are arbitrated separately. Local requests are read, write, read-modify-write or invalidate operations. Each one receives a small transaction tag. An address phase goes out as soon as the address bus is granted, even when data for earlier transactions has not yet returned. Read data arrives on the data bus in any order and is matched to its outstanding transaction by tag. Write data is sent only after its own address phase, and only once the data bus is granted.

Tags come from a free list, and the lowest free tag is always chosen. While every tag is in use, new requests are refused. A transaction's tag stays busy until its last phase ends. For a read-modify-write, the last phase is the write data that follows its read data. Every freed tag is reported as a completion bit. Read data is also returned to the local side with its tag. Data returns that match no waiting read are flagged as protocol errors and otherwise ignored.

Top module: `split_txn_master`

## Requirements
- R1: While `rst` is high at a clock edge, every output register clears. After reset, `req_ready` is high and `req_tag` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. It takes the tag shown on `req_tag`, which is the lowest-numbered tag not in use.
- R3: When all 2^TAG_W tags are in use, `req_ready` is low and `req_valid` is ignored.
- R4: `abus_req` is high while any accepted transaction still awaits its address phase. In the cycle after an edge that samples `abus_req` and `abus_gnt` both high, `a_valid` is high and carries the type, tag and address of the oldest such transaction. Type codes are 0 read, 1 write, 2 read-modify-write and 3 invalidate.
- R5: An address phase never waits for data of earlier transactions. Addresses keep issuing while reads are outstanding.
- R6: A data return (`din_valid`) whose tag is awaiting read data appears on `rd_valid`/`rd_tag`/`rd_data` in the next cycle, in whatever order the bus returns it.
- R7: A write requests the data bus (`dbus_req`) only after its address phase is issued. In the cycle after an edge that samples `dbus_req` and `dbus_gnt` both high, `d_valid` shows the oldest queued tag and its write data.
- R8: A read-modify-write keeps its tag through its read data return. It then queues a write data phase carrying its request data, and is freed only when that phase issues.
- R9: An invalidate completes, and frees its tag, when its address phase issues.
- R10: In the cycle after a tag is freed, bit t of `done_vec` is high for that tag t.
- R11: A data return whose tag is not waiting for read data raises `proto_err` in the next cycle. It changes no state and produces no `rd_valid`.
- R12: A freed tag can be allocated again in the cycle after it is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_type | input | 2 | Operation code (0 rd, 1 wr, 2 rmw, 3 inval) |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data for wr / rmw |
| req_ready | output | 1 | A tag is free, so a request can be accepted |
| req_tag | output | TAG_W | Tag the next accepted request receives |
| abus_req | output | 1 | Address bus request |
| abus_gnt | input | 1 | Address bus grant |
| a_valid | output | 1 | Address phase this cycle |
| a_type | output | 2 | Address phase operation code |
| a_tag | output | TAG_W | Address phase tag |
| a_addr | output | ADDR_W | Address phase address |
| dbus_req | output | 1 | Data bus request for outgoing write data |
| dbus_gnt | input | 1 | Data bus grant |
| d_valid | output | 1 | Outgoing write data phase |
| d_tag | output | TAG_W | Tag of outgoing data |
| d_data | output | DATA_W | Outgoing write data |
| din_valid | input | 1 | Incoming read data phase |
| din_tag | input | TAG_W | Tag of incoming data |
| din_data | input | DATA_W | Incoming read data |
| rd_valid | output | 1 | Read data returned to local side |
| rd_tag | output | TAG_W | Tag of returned read data |
| rd_data | output | DATA_W | Returned read data |
| done_vec | output | 2^TAG_W | One bit per tag freed last cycle |
| proto_err | output | 1 | Data return with a tag that is not awaiting data |

## Verification
The bench fills all tags with no grants, to catch an allocator that wraps or hands out a busy tag while `req_ready` should be low. It then grants addresses with no data returns. A design that serialises address after data would stall `a_valid` in that phase. Random traffic returns read data in shuffled tag order, so any in-order assumption shows up as a wrong `rd_tag` or a missed free. It also sends returns for idle tags and for tags still waiting for their address phase; a design that accepted those would corrupt state and mis-sequence read-modify-writes. A write queued in the same cycle as a read-modify-write's second phase exercises the two-entry push. A lost or reordered entry there would appear as a wrong `d_tag`.

// File: rtl/split_txn_pkg.sv
package split_txn_pkg;
  // Operation codes carried on req_type and a_type
  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_RMW   = 2'd2,
    OP_INVAL = 2'd3
  } op_e;

  // Progress of one tagged transaction
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_RDATA = 2'd2,
    ST_WDATA = 2'd3
  } stage_e;
endpackage

// File: rtl/tag_alloc.sv
module tag_alloc #(
  parameter int NTAGS = 8,
  parameter int TAG_W = $clog2(NTAGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [NTAGS-1:0] free_mask,
  output logic [NTAGS-1:0] busy,
  output logic [TAG_W-1:0] free_tag,
  output logic             full
);
  // Lowest free tag wins
  always_comb begin
    free_tag = '0;
    for (int i = NTAGS - 1; i >= 0; i--) begin
      if (!busy[i]) free_tag = TAG_W'(i);
    end
  end

  assign full = &busy;

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~free_mask) |
                     (alloc_en ? (NTAGS'(1) << free_tag) : '0);
  end

  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !full);
  // R2
  alloc_set_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> busy[$past(free_tag)]);
endmodule

// File: rtl/tag_fifo.sv
module tag_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_a,
  input  logic [W-1:0] data_a,
  input  logic         push_b,
  input  logic [W-1:0] data_b,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [PW-1:0] wptr_b;

  // Second push lands behind the first when both fire
  assign wptr_b = push_a ? wptr + PW'(1) : wptr;

  always_ff @(posedge clk) begin
    if (push_a) mem[wptr]   <= data_a;
    if (push_b) mem[wptr_b] <= data_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + PW'(push_a) + PW'(push_b);
      rptr  <= rptr + PW'(pop);
      count <= count + CW'(push_a) + CW'(push_b) - CW'(pop);
    end
  end

  assign head  = mem[rptr];
  assign empty = (count == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(count) + int'(push_a) + int'(push_b) - int'(pop)) <= DEPTH);
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/split_txn_master.sv
module split_txn_master
  import split_txn_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_type,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic [TAG_W-1:0]      req_tag,
  output logic                  abus_req,
  input  logic                  abus_gnt,
  output logic                  a_valid,
  output logic [1:0]            a_type,
  output logic [TAG_W-1:0]      a_tag,
  output logic [ADDR_W-1:0]     a_addr,
  output logic                  dbus_req,
  input  logic                  dbus_gnt,
  output logic                  d_valid,
  output logic [TAG_W-1:0]      d_tag,
  output logic [DATA_W-1:0]     d_data,
  input  logic                  din_valid,
  input  logic [TAG_W-1:0]      din_tag,
  input  logic [DATA_W-1:0]     din_data,
  output logic                  rd_valid,
  output logic [TAG_W-1:0]      rd_tag,
  output logic [DATA_W-1:0]     rd_data,
  output logic [(1<<TAG_W)-1:0] done_vec,
  output logic                  proto_err
);
  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] busy, free_mask;
  logic [TAG_W-1:0] free_tag, a_head, w_head;
  logic             full, accept, a_go, d_go, din_ok;
  logic             aq_empty, wq_empty, wq_push_a, wq_push_b;
  op_e              a_op, din_op;

  // Per-tag context, RAM style (no reset)
  logic [1:0]        op_tab   [NTAGS];
  logic [ADDR_W-1:0] addr_tab [NTAGS];
  logic [DATA_W-1:0] wdat_tab [NTAGS];
  stage_e            stage    [NTAGS];

  assign accept    = req_valid & ~full;
  assign req_ready = ~full;
  assign req_tag   = free_tag;

  tag_alloc #(.NTAGS(NTAGS), .TAG_W(TAG_W)) u_alloc (
    .clk(clk), .rst(rst), .alloc_en(accept), .free_mask(free_mask),
    .busy(busy), .free_tag(free_tag), .full(full)
  );

  // Tags waiting for their address tenure, oldest first
  tag_fifo #(.DEPTH(NTAGS), .W(TAG_W)) u_aq (
    .clk(clk), .rst(rst),
    .push_a(accept), .data_a(free_tag),
    .push_b(1'b0), .data_b('0),
    .pop(a_go), .head(a_head), .empty(aq_empty)
  );

  assign abus_req = ~aq_empty;
  assign a_go     = abus_req & abus_gnt;
  assign a_op     = op_e'(op_tab[a_head]);

  assign din_ok = din_valid && busy[din_tag] && (stage[din_tag] == ST_RDATA);
  assign din_op = op_e'(op_tab[din_tag]);

  // Tags waiting for an outgoing data tenure
  assign wq_push_a = a_go && (a_op == OP_WR);
  assign wq_push_b = din_ok && (din_op == OP_RMW);

  tag_fifo #(.DEPTH(NTAGS), .W(TAG_W)) u_wq (
    .clk(clk), .rst(rst),
    .push_a(wq_push_a), .data_a(a_head),
    .push_b(wq_push_b), .data_b(din_tag),
    .pop(d_go), .head(w_head), .empty(wq_empty)
  );

  assign dbus_req = ~wq_empty;
  assign d_go     = dbus_req & dbus_gnt;

  always_comb begin
    free_mask = '0;
    if (a_go && a_op == OP_INVAL) free_mask[a_head]  = 1'b1;
    if (din_ok && din_op == OP_RD) free_mask[din_tag] = 1'b1;
    if (d_go)                      free_mask[w_head]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_tab[free_tag]   <= req_type;
      addr_tab[free_tag] <= req_addr;
      wdat_tab[free_tag] <= req_wdata;
    end
  end

  // The four sources touch distinct tags: each is in a different stage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAGS; i++) stage[i] <= ST_IDLE;
    end else begin
      if (accept) stage[free_tag] <= ST_ADDR;
      if (a_go) begin
        case (a_op)
          OP_RD, OP_RMW: stage[a_head] <= ST_RDATA;
          OP_WR:         stage[a_head] <= ST_WDATA;
          default:       stage[a_head] <= ST_IDLE;
        endcase
      end
      if (din_ok) stage[din_tag] <= (din_op == OP_RMW) ? ST_WDATA : ST_IDLE;
      if (d_go)   stage[w_head]  <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid   <= 1'b0;
      a_type    <= '0;
      a_tag     <= '0;
      a_addr    <= '0;
      d_valid   <= 1'b0;
      d_tag     <= '0;
      d_data    <= '0;
      rd_valid  <= 1'b0;
      rd_tag    <= '0;
      rd_data   <= '0;
      done_vec  <= '0;
      proto_err <= 1'b0;
    end else begin
      a_valid   <= a_go;
      a_type    <= a_op;
      a_tag     <= a_head;
      a_addr    <= addr_tab[a_head];
      d_valid   <= d_go;
      d_tag     <= w_head;
      d_data    <= wdat_tab[w_head];
      rd_valid  <= din_ok;
      rd_tag    <= din_tag;
      rd_data   <= din_data;
      done_vec  <= free_mask;
      proto_err <= din_valid & ~din_ok;
    end
  end

  // R4
  addr_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    a_valid |-> $past(abus_req && abus_gnt));
  // R7
  data_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    d_valid |-> $past(dbus_req && dbus_gnt));
  // R6
  rdata_from_bus_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(din_valid) && rd_tag == $past(din_tag)));
  // R11
  err_from_bus_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(din_valid) && !rd_valid));
  // R10
  done_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(done_vec) <= 3);
endmodule

// File: tb/split_txn_master_tb.sv
module split_txn_master_tb;
  localparam int TAG_W = 3;
  localparam int NT    = 1 << TAG_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready;
  logic [2:0]  req_tag;
  logic        abus_req, abus_gnt = 1'b0;
  logic        a_valid;
  logic [1:0]  a_type;
  logic [2:0]  a_tag;
  logic [31:0] a_addr;
  logic        dbus_req, dbus_gnt = 1'b0;
  logic        d_valid;
  logic [2:0]  d_tag;
  logic [31:0] d_data;
  logic        din_valid = 1'b0;
  logic [2:0]  din_tag = '0;
  logic [31:0] din_data = '0;
  logic        rd_valid;
  logic [2:0]  rd_tag;
  logic [31:0] rd_data;
  logic [7:0]  done_vec;
  logic        proto_err;

  always #2 clk = ~clk;

  split_txn_master #(.TAG_W(TAG_W), .ADDR_W(32), .DATA_W(32)) u_dut (.*);

  // Reference model state: 0 idle, 1 addr, 2 rdata, 3 wdata
  bit          m_busy [NT];
  int          m_st   [NT];
  int          m_op   [NT];
  logic [31:0] m_addr [NT];
  logic [31:0] m_wd   [NT];
  int          aq[$];
  int          wq[$];

  bit          e_a_valid, e_d_valid, e_rd_valid, e_err;
  int          e_a_tag, e_a_type, e_d_tag, e_d_op, e_rd_tag;
  logic [31:0] e_a_addr, e_d_data, e_rd_data;
  logic [7:0]  e_done;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  int  pr_req, pr_ag, pr_dg, pr_din, pr_bad;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit m_full();
    for (int i = 0; i < NT; i++) if (!m_busy[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_lowest();
    for (int i = 0; i < NT; i++) if (!m_busy[i]) return i;
    return 0;
  endfunction

  function automatic bit m_reads_pending();
    for (int i = 0; i < NT; i++) if (m_busy[i] && m_st[i] == 2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compare_all();
    chk(req_ready == !m_full(), "R3", "req_ready", req_ready, !m_full());
    if (!m_full())
      chk(req_tag == 3'(m_lowest()), "R2 R12", "req_tag", req_tag, m_lowest());
    chk(abus_req == (aq.size() != 0), "R4", "abus_req", abus_req, aq.size() != 0);
    chk(dbus_req == (wq.size() != 0), "R7", "dbus_req", dbus_req, wq.size() != 0);
    chk(a_valid == e_a_valid, m_reads_pending() ? "R5" : "R4", "a_valid",
        a_valid, e_a_valid);
    if (e_a_valid && a_valid) begin
      chk(a_tag == 3'(e_a_tag), "R4", "a_tag", a_tag, e_a_tag);
      chk(a_type == 2'(e_a_type), "R4", "a_type", a_type, e_a_type);
      chk(a_addr == e_a_addr, "R4", "a_addr", a_addr, e_a_addr);
    end
    chk(d_valid == e_d_valid, "R7", "d_valid", d_valid, e_d_valid);
    if (e_d_valid && d_valid) begin
      chk(d_tag == 3'(e_d_tag), e_d_op == 2 ? "R8" : "R7", "d_tag", d_tag, e_d_tag);
      chk(d_data == e_d_data, e_d_op == 2 ? "R8" : "R7", "d_data", d_data, e_d_data);
    end
    chk(rd_valid == e_rd_valid, "R6", "rd_valid", rd_valid, e_rd_valid);
    if (e_rd_valid && rd_valid) begin
      chk(rd_tag == 3'(e_rd_tag), "R6", "rd_tag", rd_tag, e_rd_tag);
      chk(rd_data == e_rd_data, "R6", "rd_data", rd_data, e_rd_data);
    end
    chk(done_vec == e_done, "R10 R9", "done_vec", done_vec, e_done);
    chk(proto_err == e_err, "R11", "proto_err", proto_err, e_err);
  endtask

  // Advance the model across the coming clock edge using the driven inputs
  task automatic model_step();
    bit accept, a_go, d_go, din_ok;
    int nt, ah, wh;
    logic [7:0] fm;
    accept = req_valid && !m_full();
    nt     = m_lowest();
    a_go   = abus_gnt && aq.size() > 0;
    ah     = a_go ? aq[0] : 0;
    d_go   = dbus_gnt && wq.size() > 0;
    wh     = d_go ? wq[0] : 0;
    din_ok = din_valid && m_busy[din_tag] && m_st[din_tag] == 2;
    fm     = '0;
    e_a_valid = a_go;
    if (a_go) begin
      e_a_tag = ah; e_a_type = m_op[ah]; e_a_addr = m_addr[ah];
    end
    e_d_valid = d_go;
    if (d_go) begin
      e_d_tag = wh; e_d_op = m_op[wh]; e_d_data = m_wd[wh];
    end
    e_rd_valid = din_ok;
    if (din_ok) begin
      e_rd_tag = din_tag; e_rd_data = din_data;
    end
    e_err = din_valid && !din_ok;
    if (a_go) begin
      void'(aq.pop_front());
      case (m_op[ah])
        0, 2: m_st[ah] = 2;
        1: begin m_st[ah] = 3; wq.push_back(ah); end
        default: fm[ah] = 1'b1;
      endcase
    end
    if (din_ok) begin
      if (m_op[din_tag] == 2) begin m_st[din_tag] = 3; wq.push_back(din_tag); end
      else fm[din_tag] = 1'b1;
    end
    if (d_go) begin
      void'(wq.pop_front());
      fm[wh] = 1'b1;
    end
    for (int i = 0; i < NT; i++) if (fm[i]) begin m_busy[i] = 1'b0; m_st[i] = 0; end
    if (accept) begin
      m_busy[nt] = 1'b1; m_st[nt] = 1; m_op[nt] = req_type;
      m_addr[nt] = req_addr; m_wd[nt] = req_wdata;
      aq.push_back(nt);
    end
    e_done = fm;
  endtask

  task automatic drive_random();
    int cand[$];
    req_valid = ($urandom % 100) < pr_req;
    req_type  = 2'($urandom % 4);
    req_addr  = $urandom;
    req_wdata = $urandom;
    abus_gnt  = ($urandom % 100) < pr_ag;
    dbus_gnt  = ($urandom % 100) < pr_dg;
    din_valid = ($urandom % 100) < pr_din;
    din_data  = $urandom;
    for (int i = 0; i < NT; i++) if (m_busy[i] && m_st[i] == 2) cand.push_back(i);
    if (cand.size() > 0 && ($urandom % 100) >= pr_bad)
      din_tag = 3'(cand[$urandom % cand.size()]);
    else
      din_tag = 3'($urandom % NT);
  endtask

  task automatic run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      drive_random();
      model_step();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(req_tag == 3'd0, "R1", "req_tag", req_tag, 0);
    chk({abus_req, dbus_req, a_valid, d_valid, rd_valid, proto_err} == '0,
        "R1", "control outputs", {abus_req, dbus_req, a_valid, d_valid, rd_valid, proto_err}, 0);
    chk(done_vec == '0, "R1", "done_vec", done_vec, 0);
    rst = 1'b0;
    // R2 R3: fill every tag with no grants
    pr_req = 100; pr_ag = 0; pr_dg = 0; pr_din = 0; pr_bad = 0;
    run(12);
    chk(req_ready == 1'b0, "R3", "req_ready when full", req_ready, 0);
    // R5: addresses flow while no data returns
    pr_req = 0; pr_ag = 100;
    run(12);
    chk(abus_req == 1'b0, "R5", "all addresses issued", abus_req, 0);
    // R11: stray returns while reads and writes pending
    pr_din = 50; pr_bad = 100;
    run(20);
    // Mixed out-of-order traffic
    pr_req = 70; pr_ag = 60; pr_dg = 50; pr_din = 40; pr_bad = 15; run(1500);
    pr_req = 90; pr_ag = 20; pr_dg = 20; pr_din = 20; pr_bad = 5;  run(1500);
    pr_req = 40; pr_ag = 90; pr_dg = 90; pr_din = 70; pr_bad = 30; run(1500);
    pr_req = 100; pr_ag = 100; pr_dg = 100; pr_din = 100; pr_bad = 0; run(1500);
    // Drain: everything completes, tags all free again (R12)
    pr_req = 0; pr_ag = 100; pr_dg = 100; pr_din = 80; pr_bad = 0;
    run(300);
    chk(req_ready == 1'b1 && req_tag == 3'd0, "R12", "all tags free after drain",
        {req_ready, req_tag}, 4'b1000);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end
endmodule